// File: doc/BRIEF.md
# Descriptor Ring Dispatch Controller

This block is the register-side controller for a circular queue of command descriptors. Software programs the index of the last ring slot, which is the ring size minus one. It then writes a producer index and sets a run bit. The block walks a consumer index from its current slot toward the producer index. It hands one slot at a time to a downstream transaction engine over a request/done handshake and advances the index after each completion. When the two indices meet, it stops and clears the run bit. A descriptor that fails with its halt flag set also stops the walk, and the consumer index is left on the failing slot.

Every completion can raise a sticky status bit. A completion whose descriptor asks for an interrupt sets the done status bit. A failure sets the fault status bit when fault interrupts are enabled. Software clears either bit by writing 1 to it. The interrupt output is high while either bit is set. The base address of the ring in memory is held as two 32-bit words and driven out to the fetch logic, which is outside this block.

Top module: `dring_ctrl`

## Requirements
- R1: After reset the status word (index 3) and the control word (index 2) read 0, the size word (index 4) reads 31, and `irq` and `req_valid` are low.
- R2: The register index is `wr_addr[4:2]` / `rd_addr[4:2]`: 0 = base low word, 1 = base high word, 2 = control, 3 = status, 4 = size. Reads return data one cycle after `rd_addr` is applied. The base words read back as written and appear on `base_addr` as {high, low}. The size word keeps only bits 7:0.
- R3: The control word holds the producer index in bits 23:16, the fault interrupt enable in bit 4 and the run bit in bit 0. With run set and the consumer index different from the producer index, `req_valid` rises with `req_slot` equal to the consumer index. It stays high, with the slot stable, until `done` is sampled high. Only one request is outstanding at a time.
- R4: Each completion without a halt advances the consumer index by one. After the slot equal to the size word, the index wraps to 0. The status word reports the consumer index in bits 23:16.
- R5: When the consumer index equals the producer index and no request is outstanding, the run bit clears and no request is issued.
- R6: Status bit 0 (busy) is 1 from the first dispatch until the ring drains, halts or is stopped, and it is 1 whenever `req_valid` is high.
- R7: A completion with `done_irq` high sets status bit 5 (done status). A completion with `done_err` high sets status bit 4 (fault status) only if control bit 4 is 1.
- R8: Writing 1 to status bits 5 or 4 clears them, and writing 0 leaves them unchanged. If a clear and a new set of the same bit fall in the same cycle, the bit ends up set.
- R9: `irq` is high exactly while status bit 5 or status bit 4 is set.
- R10: A completion with both `done_err` and `done_soe` high clears the run bit and busy and leaves the consumer index on the failing slot. Setting run again dispatches that same slot first.
- R11: Writing a new producer index while the ring is running takes effect at once, so the slots appended by the write are dispatched in the same run.
- R12: Writing 0 to the run bit while a request is outstanding lets that request complete and advance the index, then no further request is issued and busy clears.
- R13: Setting run while the consumer index already equals the producer index issues no request and clears the run bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write byte address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | ADDR_W | Register read byte address |
| rd_data | output | 32 | Registered read data, one cycle after `rd_addr` |
| base_addr | output | 64 | Ring base address {high word, low word} |
| req_valid | output | 1 | Slot dispatch request to the transaction engine |
| req_slot | output | PTR_W | Ring slot being dispatched |
| done | input | 1 | Completion pulse for the outstanding request |
| done_err | input | 1 | Completed descriptor failed |
| done_soe | input | 1 | Completed descriptor requests a halt on failure |
| done_irq | input | 1 | Completed descriptor requests an interrupt |
| irq | output | 1 | Interrupt, high while a status bit is set |

## Verification
Two pairs of actions can fall in the same cycle. In the first pair, software writes 1 to clear the done status while a completion that sets the same bit is sampled. The bench drives the status write and the `done` pulse at the same edge, and the bit must read back as 1 with `irq` still high. In the second pair, a control write that moves the producer index or drops the run bit lands while a request is outstanding. The bench checks that the appended slot is dispatched next, or that nothing more is dispatched, and it follows the consumer index through the status word.

// File: rtl/dring_pkg.sv
package dring_pkg;
  localparam int REG_BASE_LO = 0;
  localparam int REG_BASE_HI = 1;
  localparam int REG_CTRL    = 2;
  localparam int REG_STAT    = 3;
  localparam int REG_SIZE    = 4;

  localparam int PTR_LSB     = 16;
  localparam int RUN_BIT     = 0;
  localparam int FIE_BIT     = 4;
  localparam int BUSY_BIT    = 0;
  localparam int FST_BIT     = 4;
  localparam int DST_BIT     = 5;
endpackage

// File: rtl/dring_wrap_inc.sv
module dring_wrap_inc #(
  parameter int PTR_W = 8
) (
  input  logic [PTR_W-1:0] cur,
  input  logic [PTR_W-1:0] last,
  output logic [PTR_W-1:0] nxt
);
  always_comb begin
    if (cur == last) nxt = '0;
    else             nxt = cur + 1'b1;
  end
endmodule

// File: rtl/dring_seq.sv
module dring_seq #(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PTR_W-1:0] head,
  input  logic [PTR_W-1:0] last,
  input  logic             run_we,
  input  logic             run_val,
  input  logic             done,
  input  logic             done_err,
  input  logic             done_soe,
  output logic [PTR_W-1:0] tail,
  output logic             run,
  output logic             busy,
  output logic             pending
);
  logic [PTR_W-1:0] tail_inc;

  dring_wrap_inc #(.PTR_W(PTR_W)) u_inc (
    .cur  (tail),
    .last (last),
    .nxt  (tail_inc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tail    <= '0;
      run     <= 1'b0;
      busy    <= 1'b0;
      pending <= 1'b0;
    end else begin
      if (pending) begin
        if (done) begin
          pending <= 1'b0;
          if (done_err && done_soe) begin
            run  <= 1'b0;
            busy <= 1'b0;
          end else begin
            tail <= tail_inc;
          end
        end
      end else if (run && (tail != head)) begin
        pending <= 1'b1;
        busy    <= 1'b1;
      end else begin
        busy <= 1'b0;
        run  <= 1'b0;
      end
      if (run_we) run <= run_val;
    end
  end
endmodule

// File: rtl/dring_irq.sv
module dring_irq (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic fire_irq,
  input  logic fire_err,
  input  logic fault_en,
  input  logic clr_we,
  input  logic clr_done,
  input  logic clr_fault,
  output logic done_st,
  output logic fault_st,
  output logic irq
);
  logic done_n, fault_n;

  always_comb begin
    done_n  = done_st;
    fault_n = fault_st;
    if (clr_we && clr_done)  done_n  = 1'b0;
    if (clr_we && clr_fault) fault_n = 1'b0;
    if (fire && fire_irq)             done_n  = 1'b1;
    if (fire && fire_err && fault_en) fault_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_st  <= 1'b0;
      fault_st <= 1'b0;
      irq      <= 1'b0;
    end else begin
      done_st  <= done_n;
      fault_st <= fault_n;
      irq      <= done_n | fault_n;
    end
  end
endmodule

// File: rtl/dring_ctrl.sv
module dring_ctrl #(
  parameter int ADDR_W     = 5,
  parameter int PTR_W      = 8,
  parameter int RESET_LAST = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic [63:0]       base_addr,
  output logic              req_valid,
  output logic [PTR_W-1:0]  req_slot,
  input  logic              done,
  input  logic              done_err,
  input  logic              done_soe,
  input  logic              done_irq,
  output logic              irq
);
  import dring_pkg::*;

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [31:0]      base_lo, base_hi;
  logic [PTR_W-1:0] head, last, tail;
  logic             fault_en, run, busy, pending;
  logic             done_st, fault_st;
  logic             ctrl_we, stat_we, fire;
  logic [31:0]      rd_mux;

  assign wr_idx  = wr_addr[ADDR_W-1:2];
  assign rd_idx  = rd_addr[ADDR_W-1:2];
  assign ctrl_we = wr_en && (wr_idx == IDX_W'(REG_CTRL));
  assign stat_we = wr_en && (wr_idx == IDX_W'(REG_STAT));
  assign fire    = pending && done;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_lo  <= '0;
      base_hi  <= '0;
      head     <= '0;
      fault_en <= 1'b0;
      last     <= PTR_W'(RESET_LAST);
    end else if (wr_en) begin
      if (wr_idx == IDX_W'(REG_BASE_LO)) base_lo <= wr_data;
      if (wr_idx == IDX_W'(REG_BASE_HI)) base_hi <= wr_data;
      if (wr_idx == IDX_W'(REG_SIZE))    last    <= wr_data[PTR_W-1:0];
      if (ctrl_we) begin
        head     <= wr_data[PTR_LSB +: PTR_W];
        fault_en <= wr_data[FIE_BIT];
      end
    end
  end

  dring_seq #(.PTR_W(PTR_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .head     (head),
    .last     (last),
    .run_we   (ctrl_we),
    .run_val  (wr_data[RUN_BIT]),
    .done     (done),
    .done_err (done_err),
    .done_soe (done_soe),
    .tail     (tail),
    .run      (run),
    .busy     (busy),
    .pending  (pending)
  );

  dring_irq u_irq (
    .clk       (clk),
    .rst       (rst),
    .fire      (fire),
    .fire_irq  (done_irq),
    .fire_err  (done_err),
    .fault_en  (fault_en),
    .clr_we    (stat_we),
    .clr_done  (wr_data[DST_BIT]),
    .clr_fault (wr_data[FST_BIT]),
    .done_st   (done_st),
    .fault_st  (fault_st),
    .irq       (irq)
  );

  assign req_valid = pending;
  assign req_slot  = tail;
  assign base_addr = {base_hi, base_lo};

  always_comb begin
    rd_mux = '0;
    case (rd_idx)
      IDX_W'(REG_BASE_LO): rd_mux = base_lo;
      IDX_W'(REG_BASE_HI): rd_mux = base_hi;
      IDX_W'(REG_CTRL): begin
        rd_mux[PTR_LSB +: PTR_W] = head;
        rd_mux[FIE_BIT]          = fault_en;
        rd_mux[RUN_BIT]          = run;
      end
      IDX_W'(REG_STAT): begin
        rd_mux[PTR_LSB +: PTR_W] = tail;
        rd_mux[DST_BIT]          = done_st;
        rd_mux[FST_BIT]          = fault_st;
        rd_mux[BUSY_BIT]         = busy;
      end
      IDX_W'(REG_SIZE): rd_mux[PTR_W-1:0] = last;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end
endmodule

// File: rtl/dring_chk.sv
module dring_chk #(
  parameter int PTR_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic [PTR_W-1:0] req_slot,
  input logic             done,
  input logic             done_err,
  input logic             done_soe,
  input logic             done_irq,
  input logic             ctrl_we,
  input logic             run,
  input logic             busy,
  input logic [PTR_W-1:0] tail,
  input logic             done_st
);
  a_r3_req_held: assert property (@(posedge clk) disable iff (rst)
    req_valid && !done |=> req_valid && $stable(req_slot));

  a_r6_busy_covers_req: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> busy);

  a_r4_tail_moves_on_done: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && done) |=> $stable(tail));

  a_r10_halt_on_fault: assert property (@(posedge clk) disable iff (rst)
    req_valid && done && done_err && done_soe && !ctrl_we |=> !run && !busy && $stable(tail));

  a_r7_done_status_set: assert property (@(posedge clk) disable iff (rst)
    req_valid && done && done_irq |=> done_st);
endmodule

bind dring_ctrl dring_chk #(.PTR_W(PTR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_slot  (req_slot),
  .done      (done),
  .done_err  (done_err),
  .done_soe  (done_soe),
  .done_irq  (done_irq),
  .ctrl_we   (ctrl_we),
  .run       (run),
  .busy      (busy),
  .tail      (tail),
  .done_st   (done_st)
);

// File: tb/test_dring_ctrl.sv
module test_dring_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [63:0] base_addr;
  logic        req_valid;
  logic [7:0]  req_slot;
  logic        done = 1'b0, done_err = 1'b0, done_soe = 1'b0, done_irq = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [7:0] mtail;

  always #2 clk = ~clk;

  dring_ctrl i_dring_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .base_addr(base_addr),
    .req_valid(req_valid), .req_slot(req_slot), .done(done), .done_err(done_err),
    .done_soe(done_soe), .done_irq(done_irq), .irq(irq)
  );

  // row: head[11:4], irq_req[3], err[2], exp done status[1], exp fault status[0]
  localparam logic [11:0] VEC [0:3] = '{
    {8'd2, 4'b1010}, {8'd1, 4'b0000}, {8'd3, 4'b0101}, {8'd0, 4'b1111}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(idx << 2); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [31:0] d);
    @(negedge clk);
    rd_addr = 5'(idx << 2);
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic wait_req(output logic [7:0] slot);
    bit seen = 1'b0;
    for (int i = 0; i < 30 && !seen; i++) begin
      @(negedge clk);
      if (req_valid) seen = 1'b1;
    end
    check("R3 request appears", 64'(seen), 64'd1);
    slot = req_slot;
  endtask

  task automatic serve(input logic irq_r, input logic err, input logic soe);
    done = 1'b1; done_irq = irq_r; done_err = err; done_soe = soe;
    @(negedge clk);
    done = 1'b0; done_irq = 1'b0; done_err = 1'b0; done_soe = 1'b0;
  endtask

  task automatic no_req(input string tag, input int n);
    bit seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (req_valid) seen = 1'b1;
    end
    check(tag, 64'(seen), 64'd0);
  endtask

  function automatic logic [7:0] inc(input logic [7:0] t);
    return (t == 8'd3) ? 8'd0 : t + 8'd1;
  endfunction

  initial begin
    #800000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  s;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(3, d); check("R1 status after reset", d, 0);
    rd(2, d); check("R1 control after reset", d, 0);
    rd(4, d); check("R1 size after reset", d, 31);
    check("R1 irq low", irq, 0);
    check("R1 req_valid low", req_valid, 0);

    // R2 base words, size field
    wr(0, 32'hDEAD_BEE0); wr(1, 32'h0000_0123);
    rd(0, d); check("R2 base low", d, 32'hDEAD_BEE0);
    rd(1, d); check("R2 base high", d, 32'h0000_0123);
    check("R2 base_addr port", base_addr, 64'h0000_0123_DEAD_BEE0);
    wr(4, 32'h0000_1203);
    rd(4, d); check("R2 size low byte only", d, 3);

    // R13 start with empty ring
    wr(2, 32'h0000_0011);
    no_req("R13 no request on empty ring", 5);
    rd(2, d); check("R13 run bit cleared", d, 32'h0000_0010);

    // table: R3 R4 R5 R6 R7 R9 R8
    mtail = 8'd0;
    for (int r = 0; r < 4; r++) begin
      logic [7:0] hd;
      hd = VEC[r][11:4];
      wr(2, {8'h0, hd, 16'h0011});
      while (mtail != hd) begin
        wait_req(s);
        check("R3 dispatched slot", s, mtail);
        rd(3, d); check("R6 busy and R4 tail while pending", d & 32'h00FF_0001, {8'h0, mtail, 16'h0001});
        check("R3 request still held", req_valid, 1);
        serve(VEC[r][3], VEC[r][2], 1'b0);
        mtail = inc(mtail);
      end
      repeat (2) @(negedge clk);
      rd(3, d);
      check("R4 R5 R7 status after drain", d, {8'h0, hd, 10'h0, VEC[r][1], VEC[r][0], 4'h0});
      check("R9 irq follows status", irq, VEC[r][1] | VEC[r][0]);
      rd(2, d); check("R5 run bit cleared on drain", d[0], 0);
      wr(3, 32'h0000_0030);
      rd(3, d); check("R8 write-1 clears status", d, {8'h0, hd, 16'h0});
      check("R9 irq low after clear", irq, 0);
    end

    // R7 fault status masked when disabled (tail 0)
    wr(2, 32'h0001_0001);
    wait_req(s); serve(1'b0, 1'b1, 1'b0);
    repeat (2) @(negedge clk);
    rd(3, d); check("R7 fault ignored when disabled", d, 32'h0001_0000);
    check("R9 irq stays low", irq, 0);

    // R8 write 0 no effect; set wins over clear (tail 1)
    wr(2, 32'h0002_0011);
    wait_req(s); serve(1'b1, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    wr(3, 32'h0000_0000);
    rd(3, d); check("R8 writing 0 keeps status", d, 32'h0002_0020);
    wr(2, 32'h0003_0011);
    wait_req(s);
    wr_en = 1'b1; wr_addr = 5'(3 << 2); wr_data = 32'h0000_0020;
    done = 1'b1; done_irq = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; done = 1'b0; done_irq = 1'b0;
    repeat (2) @(negedge clk);
    rd(3, d); check("R8 set wins over same-cycle clear", d, 32'h0003_0020);
    check("R9 irq high", irq, 1);
    wr(3, 32'h0000_0030);

    // R10 halt on fault (tail 3)
    wr(2, 32'h0001_0011);
    wait_req(s); check("R10 first slot", s, 3);
    serve(1'b0, 1'b1, 1'b1);
    no_req("R10 no dispatch after halt", 5);
    rd(3, d); check("R10 tail on failing slot, busy low", d, 32'h0003_0010);
    rd(2, d); check("R10 run cleared", d, 32'h0001_0010);
    check("R10 irq from fault", irq, 1);
    wr(3, 32'h0000_0030);
    wr(2, 32'h0001_0011);
    wait_req(s); check("R10 restart redispatches failing slot", s, 3);
    serve(1'b0, 1'b0, 1'b0);
    wait_req(s); check("R4 wrap to slot 0", s, 0);
    serve(1'b0, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    rd(3, d); check("R5 drained after restart", d, 32'h0001_0000);

    // R11 append while running (tail 1)
    wr(2, 32'h0002_0011);
    wait_req(s); check("R11 first slot", s, 1);
    wr(2, 32'h0003_0011);
    serve(1'b0, 1'b0, 1'b0);
    wait_req(s); check("R11 appended slot dispatched", s, 2);
    serve(1'b0, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    rd(3, d); check("R11 tail reaches new head", d, 32'h0003_0000);

    // R12 software stop (tail 3)
    wr(2, 32'h0002_0011);
    wait_req(s); check("R12 first slot", s, 3);
    wr(2, 32'h0002_0010);
    check("R12 request held after stop write", req_valid, 1);
    serve(1'b0, 1'b0, 1'b0);
    no_req("R12 no dispatch after stop", 5);
    rd(3, d); check("R12 tail advanced, busy low", d, 32'h0000_0000);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule